// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block is the digital front end of a small non-volatile byte store reached over a four-wire serial bus. The storage is a register array of 512 bytes. A host selects the block with an active-low select, clocks bits in on a serial input and reads bits back on a serial output. The bus uses clock polarity 0 with the second-edge phase. The host drives data on the rising clock edge, and the block samples it on the falling edge. All bus inputs are brought into the system clock domain by a synchronizer, and clock edges are found by oversampling. Every transfer is framed in whole bytes, and every command opens with an instruction byte.

The command set covers six instructions: array read, array write, set-enable, clear-enable, status read and status write. An array write fills one 4-byte page with one to four bytes. The write is committed when select rises, and it then starts a self-timed busy interval of `BUSY_CYCLES` system clocks. A program only happens when four conditions hold: the software enable latch is set, the write-unlock pin is high, the target page is outside the protected block, and the busy interval has not started. A pause input freezes the serial stream in the middle of a transfer and releases the output.

The controller is a single state machine with eight states:
- `ST_IDLE`: select is high.
- `ST_OPCODE`: the instruction byte is being collected.
- `ST_ADDR`: the low address byte is being collected.
- `ST_RD_DATA`: array bytes are streamed out.
- `ST_WR_DATA`: page bytes are collected.
- `ST_STAT_RD`: status bytes are streamed out.
- `ST_STAT_WR`: the status byte is collected.
- `ST_SKIP`: input is ignored until select rises.

Transitions:
- Any state goes to `ST_IDLE` when select is high.
- `ST_IDLE` goes to `ST_OPCODE` once select is low.
- After the instruction byte, `ST_OPCODE` branches as follows:
  - read or write goes to `ST_ADDR`;
  - status read goes to `ST_STAT_RD`;
  - status write goes to `ST_STAT_WR`;
  - set-enable, clear-enable, an unknown code, or any instruction other than status read while busy goes to `ST_SKIP`.
- After the address byte, `ST_ADDR` goes to `ST_WR_DATA` for a write and to `ST_RD_DATA` for a read.
- The remaining states hold until select rises.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00: busy bit 0 is clear, enable bit 1 is clear and protect level bits 3:2 are 00.
- R2: Instruction codes are 0x06 set-enable, 0x04 clear-enable, 0x05 status read, 0x01 status write, 0000_A011 read and 0000_A010 write. In the read and write codes, A is address bit 8, and the next byte carries address bits 7:0. Bytes travel most-significant bit first. A read streams consecutive bytes and wraps from 511 to 0.
- R3: An array write sent without a prior set-enable leaves the array unchanged and starts no busy interval.
- R4: A write programs only the whole bytes received, from 1 to 4. The offset within the 4-byte page wraps from 3 to 0. Trailing bits of an incomplete byte are dropped, and the other bytes of the page keep their contents.
- R5: A committed write holds status bit 0 high for BUSY_CYCLES clocks. The status can be read during that time. Any instruction other than status read is ignored while busy.
- R6: Set-enable sets status bit 1 and clear-enable clears it. The bit also clears on its own when a program interval ends.
- R7: With the write-unlock pin low, neither an array write nor a status write takes effect.
- R8: Protect level 1 blocks addresses 384 to 511, level 2 blocks 256 to 511 and level 3 blocks the whole array. Level 0 blocks nothing.
- R9: While the pause input is low, serial clock edges are ignored and the output enable is low. When pause is released, the transfer continues from the bit where it stopped.
- R10: The output enable is high while the block is selected and not paused, and low while select is high.
- R11: A status write copies data bits 3:2 into the protect level. It needs the enable latch and write-unlock, and it runs a busy interval.
- R12: An unknown instruction code is ignored along with the rest of its transfer. The state is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select; a rising edge ends the instruction |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Active-low pause of the serial stream |
| wr_unlock | input | 1 | Must be high for any program to happen |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for so (low means high impedance) |

## Verification
The hardest case to reach from the ports is an instruction that arrives while a program is still running. The bench has to land inside a window that exists only between the rise of select and the end of the busy count. To do this, it keeps the busy count larger than two full instruction frames. It then issues a status read and a clear-enable back to back, right after the commit. A second status read shows whether the clear-enable was ignored while the busy bit was still set. The pause case is reached by stopping between bit 3 and bit 4 of a streamed byte. The bench then toggles the clock while paused and checks that the byte still arrives intact.

// File: rtl/spee_pkg.sv
package spee_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_STAT_RD,
        ST_STAT_WR,
        ST_SKIP
    } spee_state_t;

    localparam logic [7:0] OP_SET_EN = 8'h06;
    localparam logic [7:0] OP_CLR_EN = 8'h04;
    localparam logic [7:0] OP_ST_RD  = 8'h05;
    localparam logic [7:0] OP_ST_WR  = 8'h01;
    localparam logic [2:0] OP_RD_LO  = 3'b011;
    localparam logic [2:0] OP_WR_LO  = 3'b010;

    // protect level against the two top address bits of a page
    function automatic logic prot_hit(input logic [1:0] lvl, input logic [1:0] top2);
        unique case (lvl)
            2'd0:    prot_hit = 1'b0;
            2'd1:    prot_hit = (top2 == 2'b11);
            2'd2:    prot_hit = top2[1];
            default: prot_hit = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/spee_sync.sv
module spee_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spee_shifter.sv
module spee_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       rise,
    input  logic       fall,
    input  logic       si,
    input  logic       ld,
    input  logic [7:0] ld_byte,
    output logic       so,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic [2:0] bit_cnt
);
    logic [6:0] rx_sr;
    logic [7:0] tx_sr;

    assign rx_byte   = {rx_sr, si};
    assign byte_done = fall && !clear && (bit_cnt == 3'd7);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr   <= '0;
            bit_cnt <= '0;
        end else if (clear) begin
            bit_cnt <= '0;
        end else if (fall) begin
            rx_sr   <= rx_byte[6:0];
            bit_cnt <= bit_cnt + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            so    <= 1'b0;
        end else if (ld) begin
            tx_sr <= ld_byte;
        end else if (rise) begin
            so    <= tx_sr[7];
            tx_sr <= {tx_sr[6:0], 1'b0};
        end
    end
endmodule

// File: rtl/spee_timer.sv
module spee_timer #(
    parameter int CYCLES = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign done = busy && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
    import spee_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int PAGE_BYTES  = 4,
    parameter int BUSY_CYCLES = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wr_unlock,
    output logic so,
    output logic so_oe
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int OFF_W = $clog2(PAGE_BYTES);

    // synchronized bus inputs: {cs, sck, si, hold, unlock}
    logic [4:0] raw_v, sync_v;
    logic cs_s, sck_s, si_s, hold_s, unlock_s;
    logic cs_d, sck_d;

    assign raw_v = {cs_n, sck, si, hold_n, wr_unlock};
    assign {cs_s, sck_s, si_s, hold_s, unlock_s} = sync_v;

    spee_sync #(.W(5), .RST_VAL(5'b10010)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_v), .q(sync_v)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
        end
    end

    logic active, sck_rise, sck_fall, cs_rise;
    assign active   = !cs_s && hold_s;
    assign sck_rise = active && sck_s && !sck_d;
    assign sck_fall = active && !sck_s && sck_d;
    assign cs_rise  = cs_s && !cs_d;

    // shifter
    logic       byte_done, tx_ld;
    logic [7:0] rx, tx_byte;
    logic [2:0] bit_cnt;

    spee_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .clear(cs_s), .rise(sck_rise), .fall(sck_fall),
        .si(si_s), .ld(tx_ld), .ld_byte(tx_byte), .so(so),
        .byte_done(byte_done), .rx_byte(rx), .bit_cnt(bit_cnt)
    );

    assign so_oe = active;

    // busy timer
    logic busy, prog_done, prog_start;
    spee_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy), .done(prog_done)
    );

    // state and datapath registers
    spee_state_t st, st_nx;
    logic                  wel;
    logic [1:0]            bp;
    logic                  a_hi, is_wr;
    logic [ADDR_W-1:0]     addr;
    logic [OFF_W-1:0]      poff;
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pmask;
    logic [1:0]            sr_pend;
    logic                  sr_got;
    logic [7:0]            mem [DEPTH];
    logic [7:0]            status;

    assign status = {4'b0000, bp, wel, busy};

    logic op_rd, op_wr;
    assign op_rd = (rx[7:4] == 4'h0) && (rx[2:0] == OP_RD_LO);
    assign op_wr = (rx[7:4] == 4'h0) && (rx[2:0] == OP_WR_LO);

    logic arr_commit, sr_commit;
    assign arr_commit = cs_rise && (st == ST_WR_DATA) && wel && unlock_s && !busy
                        && (|pmask) && !prot_hit(bp, addr[ADDR_W-1 -: 2]);
    assign sr_commit  = cs_rise && (st == ST_STAT_WR) && sr_got && wel && unlock_s && !busy;
    assign prog_start = arr_commit || sr_commit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        if (cs_s) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:   st_nx = ST_OPCODE;
                ST_OPCODE: if (byte_done) begin
                    if (busy && rx != OP_ST_RD) st_nx = ST_SKIP;
                    else if (rx == OP_ST_RD)    st_nx = ST_STAT_RD;
                    else if (rx == OP_ST_WR)    st_nx = ST_STAT_WR;
                    else if (op_rd || op_wr)    st_nx = ST_ADDR;
                    else                        st_nx = ST_SKIP;
                end
                ST_ADDR:   if (byte_done) st_nx = is_wr ? ST_WR_DATA : ST_RD_DATA;
                ST_RD_DATA, ST_WR_DATA, ST_STAT_RD, ST_STAT_WR, ST_SKIP: st_nx = st;
                default:   st_nx = ST_IDLE;
            endcase
        end
    end

    // output byte loading
    always_comb begin
        tx_ld   = 1'b0;
        tx_byte = 8'h00;
        if (byte_done) begin
            unique case (st)
                ST_OPCODE:  if (rx == OP_ST_RD) begin tx_ld = 1'b1; tx_byte = status; end
                ST_ADDR:    if (!is_wr) begin tx_ld = 1'b1; tx_byte = mem[{a_hi, rx}]; end
                ST_RD_DATA: begin tx_ld = 1'b1; tx_byte = mem[addr + 1'b1]; end
                ST_STAT_RD: begin tx_ld = 1'b1; tx_byte = status; end
                default:    tx_ld = 1'b0;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel     <= 1'b0;
            bp      <= 2'b00;
            a_hi    <= 1'b0;
            is_wr   <= 1'b0;
            addr    <= '0;
            poff    <= '0;
            pmask   <= '0;
            sr_pend <= 2'b00;
            sr_got  <= 1'b0;
            for (int k = 0; k < PAGE_BYTES; k++) pbuf[k] <= 8'h00;
        end else begin
            if (byte_done) begin
                unique case (st)
                    ST_OPCODE: if (!busy) begin
                        if (rx == OP_SET_EN) wel <= 1'b1;
                        if (rx == OP_CLR_EN) wel <= 1'b0;
                        a_hi   <= rx[3];
                        is_wr  <= op_wr;
                        sr_got <= 1'b0;
                    end
                    ST_ADDR: begin
                        addr  <= {a_hi, rx};
                        poff  <= rx[OFF_W-1:0];
                        pmask <= '0;
                    end
                    ST_RD_DATA: addr <= addr + 1'b1;
                    ST_WR_DATA: begin
                        pbuf[poff]  <= rx;
                        pmask[poff] <= 1'b1;
                        poff        <= poff + 1'b1;
                    end
                    ST_STAT_WR: if (!sr_got) begin
                        sr_pend <= rx[3:2];
                        sr_got  <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (sr_commit) bp  <= sr_pend;
            if (prog_done) wel <= 1'b0;
        end
    end

    // storage array, page-wide write port
    always_ff @(posedge clk) begin
        if (arr_commit) begin
            for (int k = 0; k < PAGE_BYTES; k++) begin
                if (pmask[k]) mem[{addr[ADDR_W-1:OFF_W], OFF_W'(k)}] <= pbuf[k];
            end
        end
    end
endmodule

// File: rtl/spee_ctrl_chk.sv
module spee_ctrl_chk
    import spee_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       wel,
    input logic       start,
    input logic       arr_we,
    input logic       hold_s,
    input logic       cs_s,
    input logic [2:0] bit_cnt,
    input logic [2:0] st
);
    AST_WEL_CLEARED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);  // R6

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));  // R5

    AST_NO_PROGRAM_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !arr_we);  // R5

    AST_PAUSE_FREEZES_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_s && !cs_s) |=> $stable(bit_cnt));  // R9

    AST_IDLE_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'(ST_IDLE)) |-> (bit_cnt == 3'd0));  // R2
endmodule

bind spi_eeprom_ctrl spee_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel), .start(prog_start),
    .arr_we(arr_commit), .hold_s(hold_s), .cs_s(cs_s), .bit_cnt(bit_cnt), .st(st)
);

// File: tb/spi_eeprom_ctrl_tb.sv
module spi_eeprom_ctrl_tb;
    localparam int BUSY = 300;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wr_unlock = 1'b1;
    logic so, so_oe;

    always #2 clk = ~clk;

    spi_eeprom_ctrl #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wr_unlock(wr_unlock), .so(so), .so_oe(so_oe)
    );

    int errs = 0, nchk = 0;
    bit finished = 1'b0;
    logic [7:0] mdl [512];
    logic [7:0] wbuf [4];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b, output logic r);
        si = b; sck = 1'b1; tick(HALF);
        r = so; sck = 1'b0; tick(HALF);
    endtask

    task automatic spi_byte(input logic [7:0] d, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) spi_bit(d[i], r[i]);
    endtask

    task automatic cs_lo(); cs_n = 1'b0; tick(6); endtask
    task automatic cs_hi(); tick(2); cs_n = 1'b1; tick(6); endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        cs_lo(); spi_byte(op, r); cs_hi();
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [7:0] r;
        cs_lo(); spi_byte(8'h05, r); spi_byte(8'h00, s); cs_hi();
    endtask

    task automatic wr_status(input logic [7:0] v);
        logic [7:0] r;
        cs_lo(); spi_byte(8'h01, r); spi_byte(v, r); cs_hi();
    endtask

    // send n bytes of wbuf to address a; update the model when it should land
    task automatic wr_bytes(input logic [8:0] a, input int n, input bit lands);
        logic [7:0] r;
        cs_lo();
        spi_byte({4'h0, a[8], 3'b010}, r);
        spi_byte(a[7:0], r);
        for (int i = 0; i < n; i++) begin
            spi_byte(wbuf[i], r);
            if (lands) mdl[{a[8:2], 2'(a[1:0] + i)}] = wbuf[i];
        end
        cs_hi();
    endtask

    task automatic rd_check(input logic [8:0] a, input int n, input string req);
        logic [7:0] r;
        cs_lo();
        spi_byte({4'h0, a[8], 3'b011}, r);
        spi_byte(a[7:0], r);
        for (int i = 0; i < n; i++) begin
            spi_byte(8'h00, r);
            chk(req, {24'h0, r}, {24'h0, mdl[9'(a + i)]});
        end
        cs_hi();
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        if (!finished) begin
            errs++; nchk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, r;
        logic b;
        tick(5); rst_n = 1'b1; tick(5);

        // R10: idle output enable
        chk("R10 idle oe", {31'h0, so_oe}, 32'h0);
        // R1: reset status, R10 enable while selected
        cs_lo(); spi_byte(8'h05, r);
        chk("R10 selected oe", {31'h0, so_oe}, 32'h1);
        spi_byte(8'h00, s); cs_hi();
        chk("R1 reset status", {24'h0, s}, 32'h00);

        // R6: set and clear enable
        cmd1(8'h06); rd_status(s); chk("R6 set-enable", {24'h0, s}, 32'h02);
        cmd1(8'h04); rd_status(s); chk("R6 clear-enable", {24'h0, s}, 32'h00);

        // R4 full pages over the whole array
        for (int p = 0; p < 128; p++) begin
            for (int i = 0; i < 4; i++) wbuf[i] = 8'((p * 4 + i) * 37 + (p / 64) * 91);
            cmd1(8'h06);
            wr_bytes(9'(p * 4), 4, 1'b1);
            if (p == 0) begin
                rd_status(s); chk("R5 busy during program", {24'h0, s}, 32'h03);
                cmd1(8'h04);
                rd_status(s); chk("R5 clear-enable ignored while busy", {24'h0, s}, 32'h03);
                tick(BUSY);
                rd_status(s); chk("R6 enable clears after program", {24'h0, s}, 32'h00);
            end else begin
                tick(BUSY + 10);
            end
        end
        // R2: one long read across the wrap point 511 -> 0
        rd_check(9'd0, 513, "R2 sequential read");

        // R4: page offset wrap 2,3,0
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        cmd1(8'h06); wr_bytes(9'h106, 3, 1'b1); tick(BUSY + 10);
        rd_check(9'h104, 4, "R4 page wrap");

        // R4: one byte then three stray bits
        wbuf[0] = 8'h5E;
        cmd1(8'h06);
        cs_lo(); spi_byte(8'h02, r); spi_byte(8'h10, r); spi_byte(wbuf[0], r);
        for (int i = 0; i < 3; i++) spi_bit(1'b1, b);
        cs_hi(); mdl[9'h010] = 8'h5E; tick(BUSY + 10);
        rd_check(9'h010, 4, "R4 partial page");

        // R3: no enable
        wbuf[0] = 8'h77; wr_bytes(9'h020, 1, 1'b0);
        rd_status(s); chk("R3 no busy without enable", {24'h0, s}, 32'h00);
        rd_check(9'h020, 1, "R3 array unchanged");

        // R7: unlock pin low blocks array and status writes
        wr_unlock = 1'b0;
        cmd1(8'h06); wbuf[0] = 8'h66; wr_bytes(9'h024, 1, 1'b0); tick(BUSY + 10);
        rd_check(9'h024, 1, "R7 array write blocked");
        wr_status(8'h0C); tick(BUSY + 10);
        rd_status(s); chk("R7 status write blocked", {24'h0, s}, 32'h02);
        cmd1(8'h04); wr_unlock = 1'b1;

        // R8/R11: each protect level against one address per quarter
        for (int lvl = 1; lvl < 4; lvl++) begin
            cmd1(8'h06); wr_status(8'(lvl << 2)); tick(BUSY + 10);
            rd_status(s); chk("R11 protect level written", {24'h0, s}, 32'(lvl << 2));
            for (int q = 0; q < 4; q++) begin
                logic [8:0] a;
                bit pr;
                a = 9'(q * 128 + 64);
                pr = (lvl == 3) || (lvl == 2 && a >= 256) || (lvl == 1 && a >= 384);
                wbuf[0] = ~mdl[a];
                cmd1(8'h06); wr_bytes(a, 1, !pr); tick(BUSY + 10);
                if (pr) cmd1(8'h04);
                rd_check(a, 1, "R8 block protect");
            end
        end
        cmd1(8'h06); wr_status(8'h00); tick(BUSY + 10);
        rd_status(s); chk("R11 level cleared", {24'h0, s}, 32'h00);

        // R9: pause inside a streamed byte
        cs_lo(); spi_byte(8'h03, r); spi_byte(8'h00, r);
        for (int i = 7; i >= 5; i--) spi_bit(1'b0, r[i]);
        hold_n = 1'b0; tick(6);
        chk("R9 output released in pause", {31'h0, so_oe}, 32'h0);
        for (int i = 0; i < 2; i++) spi_bit(1'b1, b);
        hold_n = 1'b1; tick(6);
        for (int i = 4; i >= 0; i--) spi_bit(1'b0, r[i]);
        cs_hi();
        chk("R9 byte intact after pause", {24'h0, r}, {24'h0, mdl[0]});

        // R12: unknown code with trailing bytes
        cmd1(8'h06);
        cs_lo(); spi_byte(8'hFF, r); spi_byte(8'h04, r); spi_byte(8'h02, r); cs_hi();
        rd_status(s); chk("R12 unknown code ignored", {24'h0, s}, 32'h02);
        cmd1(8'h04);
        rd_check(9'h000, 2, "R12 array untouched");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end
endmodule